// File: doc/BRIEF.md
# Storage Address Validity Checker

This block receives a five-character decimal storage address one character per clock, highest-order position first, and judges whether the address is usable. Each character is six bits wide: two zone bits and a four-bit numeric field. The block turns the five numeric fields into a binary address value. It also collects the zone bits of the two middle positions as an index tag.

Three kinds of fault are reported, each on its own sticky flag:
- a numeric field that is not a decimal digit;
- a zone bit on a position where zones are not permitted;
- an address at or above the installed storage capacity.

A capacity select input picks one of five storage sizes. The flags are updated only when an address is complete. They stay set until a clear pulse or a reset, so a controller can run a batch of addresses and inspect the outcome once.

Top module: `stg_addr_check`

## Requirements
- R1: Characters taken on `char_vld` fill the positions in the order ten-thousands, thousands, hundreds, tens, units. After the clock edge that takes the fifth character, `done` is high for exactly one cycle and `addr_bin` holds the decimal value of the address in binary.
- R2: A character is `{B, A, n8, n4, n2, n1}` with the zone bits at [5:4]. Numeric code 4'b1010 means digit 0, and codes 4'b0001 to 4'b1001 mean digits 1 to 9.
- R3: Numeric code 4'b0000 (blank) and codes 4'b1011 to 4'b1111 are not digits. Such a code counts as 0 in `addr_bin`, and it sets `err_digit` at the completion of that address.
- R4: A set zone bit on the ten-thousands, thousands or units position sets `err_zone` at completion. Zone bits on the hundreds and tens positions never raise an error.
- R5: `index_tag` is {hundreds B, hundreds A, tens B, tens A} of the last completed address.
- R6: `cap_sel` values 0, 1, 2, 3 and 4 select 10000, 20000, 40000, 60000 and 80000 positions; values 5 to 7 select 10000. If the completed value is greater than or equal to the capacity sampled with the fifth character, `err_range` is set.
- R7: The error flags are sticky. They change only at an address completion or on `clr`. A `clr` pulse clears all flags by the next cycle and discards any partly entered address.
- R8: In cycles with `char_vld` low, the partial address is kept unchanged, so idle gaps between characters do not alter the result.
- R9: After reset, `done`, `addr_bin`, `index_tag` and all error flags are zero, and assembly starts at the ten-thousands position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clears sticky flags and discards a partial address |
| char_vld | input | 1 | Character present this cycle |
| char_in | input | 6 | Address character {B, A, 8, 4, 2, 1} |
| cap_sel | input | 3 | Installed capacity select |
| done | output | 1 | One-cycle pulse when an address completes |
| addr_bin | output | 17 | Binary value of the last completed address |
| index_tag | output | 4 | Zone bits of hundreds and tens positions |
| err_digit | output | 1 | Sticky non-digit flag |
| err_zone | output | 1 | Sticky forbidden-zone flag |
| err_range | output | 1 | Sticky over-capacity flag |

## Verification
The main function is exercised with pairs of addresses that sit on either side of each capacity boundary, for example 79999 and 80000 at the largest size, and 10000 at 10k and at 20k. These pairs separate an off-by-one compare from a wrong capacity decode. Zone patterns are placed on each of the five positions in turn, which separates the two tag positions from the three forbidden ones and checks the order of the tag bits. Blank and out-of-range numeric codes are placed in different positions to show that they are caught and weighted as zero. Directed sequences then cover idle gaps between characters, a clear in the middle of an address, flags staying clear before the fifth character, and flags persisting across a following clean address.

// File: rtl/sacv_pkg.sv
package sacv_pkg;

    localparam int NPOS   = 5;
    localparam int CHW    = 6;
    localparam int NUMW   = 4;
    localparam int VALW   = 17;
    localparam int TAGW   = 4;
    localparam int SELW   = 3;
    localparam int NCAP   = 5;
    localparam int PW     = $clog2(NPOS);

    typedef struct packed {
        logic            zb;
        logic            za;
        logic [NUMW-1:0] num;
    } bcd_char_t;

    typedef struct packed {
        logic            ok;
        logic [NUMW-1:0] val;
    } digit_t;

    typedef enum logic [SELW-1:0] {
        CAP_10K = 3'd0,
        CAP_20K = 3'd1,
        CAP_40K = 3'd2,
        CAP_60K = 3'd3,
        CAP_80K = 3'd4
    } cap_e;

    typedef struct packed {
        logic [VALW-1:0] value;
        logic [TAGW-1:0] tag;
        logic            dig_bad;
        logic            zone_bad;
    } addr_res_t;

    // Numeric field to decimal digit; zero uses the 8+2 code.
    function automatic digit_t decode_num(input logic [NUMW-1:0] n);
        digit_t d;
        if (n == 4'b1010) begin
            d.ok  = 1'b1;
            d.val = 4'd0;
        end else if (n >= 4'd1 && n <= 4'd9) begin
            d.ok  = 1'b1;
            d.val = n;
        end else begin
            d.ok  = 1'b0;
            d.val = 4'd0;
        end
        return d;
    endfunction

    function automatic logic [VALW-1:0] cap_limit(input logic [SELW-1:0] sel);
        logic [VALW-1:0] c;
        case (cap_e'(sel))
            CAP_10K: c = VALW'(10000);
            CAP_20K: c = VALW'(20000);
            CAP_40K: c = VALW'(40000);
            CAP_60K: c = VALW'(60000);
            CAP_80K: c = VALW'(80000);
            default: c = VALW'(10000);
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sacv_char_decode.sv
module sacv_char_decode
    import sacv_pkg::*;
#(
    parameter int TAG_HI_POS = 2,
    parameter int TAG_LO_POS = 3
) (
    input  bcd_char_t     ch,
    input  logic [PW-1:0] pos,
    output digit_t        dig,
    output logic          zone_bad,
    output logic          at_tag_hi,
    output logic          at_tag_lo
);
    logic has_zone;

    always_comb begin
        dig       = decode_num(ch.num);
        has_zone  = ch.zb | ch.za;
        at_tag_hi = (pos == PW'(TAG_HI_POS));
        at_tag_lo = (pos == PW'(TAG_LO_POS));
        zone_bad  = has_zone & ~(at_tag_hi | at_tag_lo);
    end
endmodule

// File: rtl/sacv_assembler.sv
module sacv_assembler
    import sacv_pkg::*;
#(
    parameter int TAG_HI_POS = 2,
    parameter int TAG_LO_POS = 3
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      clr,
    input  logic      vld,
    input  bcd_char_t ch,
    output logic      fin_stb,
    output addr_res_t fin
);
    logic [PW-1:0]   pos_q;
    logic [VALW-1:0] acc_q;
    logic [TAGW-1:0] tag_q;
    logic            dig_bad_q;
    logic            zone_bad_q;

    digit_t          dig;
    logic            zone_bad_now;
    logic            at_hi;
    logic            at_lo;
    logic            last_pos;
    logic [VALW-1:0] next_val;
    logic [TAGW-1:0] tag_n;

    sacv_char_decode #(
        .TAG_HI_POS(TAG_HI_POS),
        .TAG_LO_POS(TAG_LO_POS)
    ) u_dec (
        .ch        (ch),
        .pos       (pos_q),
        .dig       (dig),
        .zone_bad  (zone_bad_now),
        .at_tag_hi (at_hi),
        .at_tag_lo (at_lo)
    );

    always_comb begin
        last_pos = (pos_q == PW'(NPOS - 1));
        next_val = (acc_q * VALW'(10)) + VALW'(dig.val);
        tag_n    = tag_q;
        if (at_hi) tag_n[3:2] = {ch.zb, ch.za};
        if (at_lo) tag_n[1:0] = {ch.zb, ch.za};
        fin.value    = next_val;
        fin.tag      = tag_n;
        fin.dig_bad  = dig_bad_q | ~dig.ok;
        fin.zone_bad = zone_bad_q | zone_bad_now;
        fin_stb      = vld & ~clr & last_pos;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pos_q      <= '0;
            acc_q      <= '0;
            tag_q      <= '0;
            dig_bad_q  <= 1'b0;
            zone_bad_q <= 1'b0;
        end else if (vld) begin
            if (last_pos) begin
                pos_q      <= '0;
                acc_q      <= '0;
                tag_q      <= '0;
                dig_bad_q  <= 1'b0;
                zone_bad_q <= 1'b0;
            end else begin
                pos_q      <= pos_q + PW'(1);
                acc_q      <= next_val;
                tag_q      <= tag_n;
                dig_bad_q  <= fin.dig_bad;
                zone_bad_q <= fin.zone_bad;
            end
        end
    end
endmodule

// File: rtl/sacv_range_cmp.sv
module sacv_range_cmp
    import sacv_pkg::*;
(
    input  logic [VALW-1:0] value,
    input  logic [SELW-1:0] sel,
    output logic            over
);
    logic [NCAP-1:0] over_v;

    for (genvar i = 0; i < NCAP; i++) begin : g_cap
        assign over_v[i] = (value >= cap_limit(SELW'(i)));
    end

    always_comb begin
        if (sel < SELW'(NCAP)) over = over_v[sel];
        else                   over = over_v[0];
    end
endmodule

// File: rtl/sacv_result_reg.sv
module sacv_result_reg
    import sacv_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            fin_stb,
    input  addr_res_t       fin,
    input  logic            over,
    output logic            done,
    output logic [VALW-1:0] addr_bin,
    output logic [TAGW-1:0] index_tag,
    output logic            err_digit,
    output logic            err_zone,
    output logic            err_range
);
    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            addr_bin  <= '0;
            index_tag <= '0;
            err_digit <= 1'b0;
            err_zone  <= 1'b0;
            err_range <= 1'b0;
        end else begin
            done <= fin_stb;
            if (fin_stb) begin
                addr_bin  <= fin.value;
                index_tag <= fin.tag;
            end
            if (clr) begin
                err_digit <= 1'b0;
                err_zone  <= 1'b0;
                err_range <= 1'b0;
            end else if (fin_stb) begin
                err_digit <= err_digit | fin.dig_bad;
                err_zone  <= err_zone  | fin.zone_bad;
                err_range <= err_range | over;
            end
        end
    end
endmodule

// File: rtl/stg_addr_check.sv
module stg_addr_check
    import sacv_pkg::*;
#(
    parameter int TAG_HI_POS = 2,
    parameter int TAG_LO_POS = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            char_vld,
    input  logic [CHW-1:0]  char_in,
    input  logic [SELW-1:0] cap_sel,
    output logic            done,
    output logic [VALW-1:0] addr_bin,
    output logic [TAGW-1:0] index_tag,
    output logic            err_digit,
    output logic            err_zone,
    output logic            err_range
);
    bcd_char_t ch;
    addr_res_t fin;
    logic      fin_stb;
    logic      over;

    assign ch = bcd_char_t'(char_in);

    sacv_assembler #(
        .TAG_HI_POS(TAG_HI_POS),
        .TAG_LO_POS(TAG_LO_POS)
    ) u_asm (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .vld     (char_vld),
        .ch      (ch),
        .fin_stb (fin_stb),
        .fin     (fin)
    );

    sacv_range_cmp u_rng (
        .value (fin.value),
        .sel   (cap_sel),
        .over  (over)
    );

    sacv_result_reg u_res (
        .clk       (clk),
        .rst       (rst),
        .clr       (clr),
        .fin_stb   (fin_stb),
        .fin       (fin),
        .over      (over),
        .done      (done),
        .addr_bin  (addr_bin),
        .index_tag (index_tag),
        .err_digit (err_digit),
        .err_zone  (err_zone),
        .err_range (err_range)
    );
endmodule

// File: rtl/sacv_checker.sv
module sacv_checker
    import sacv_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            clr,
    input logic            char_vld,
    input logic [SELW-1:0] cap_sel,
    input logic            done,
    input logic [VALW-1:0] addr_bin,
    input logic            err_digit,
    input logic            err_zone,
    input logic            err_range
);
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R1
    AST_DONE_FROM_CHAR: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(char_vld) && !$past(clr))); // R1
    AST_DIGIT_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(err_digit) |-> done); // R3
    AST_ZONE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        $rose(err_zone) |-> done); // R4
    AST_RANGE_BOUND: assert property (@(posedge clk) disable iff (rst)
        (done && !err_range) |-> (addr_bin < cap_limit($past(cap_sel)))); // R6
    AST_CLR_CLEARS: assert property (@(posedge clk) disable iff (rst)
        clr |=> !(err_digit || err_zone || err_range)); // R7
    AST_DIGIT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_digit && !clr) |=> err_digit); // R7
    AST_RANGE_STICKY: assert property (@(posedge clk) disable iff (rst)
        (err_range && !clr) |=> err_range); // R7
    AST_VALUE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !done |=> (done || $stable(addr_bin))); // R8
endmodule

bind stg_addr_check sacv_checker u_sacv_checker (
    .clk       (clk),
    .rst       (rst),
    .clr       (clr),
    .char_vld  (char_vld),
    .cap_sel   (cap_sel),
    .done      (done),
    .addr_bin  (addr_bin),
    .err_digit (err_digit),
    .err_zone  (err_zone),
    .err_range (err_range)
);

// File: tb/stg_addr_check_bench.sv
module stg_addr_check_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr = 1'b0;
    logic        char_vld = 1'b0;
    logic [5:0]  char_in = '0;
    logic [2:0]  cap_sel = '0;
    logic        done;
    logic [16:0] addr_bin;
    logic [3:0]  index_tag;
    logic        err_digit, err_zone, err_range;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    stg_addr_check u_stg_addr_check (
        .clk(clk), .rst(rst), .clr(clr), .char_vld(char_vld),
        .char_in(char_in), .cap_sel(cap_sel), .done(done),
        .addr_bin(addr_bin), .index_tag(index_tag),
        .err_digit(err_digit), .err_zone(err_zone), .err_range(err_range)
    );

    // Character codes {B, A, 8, 4, 2, 1}
    localparam logic [5:0] D0 = 6'b001010, D1 = 6'b000001, D2 = 6'b000010;
    localparam logic [5:0] D3 = 6'b000011, D4 = 6'b000100, D5 = 6'b000101;
    localparam logic [5:0] D7 = 6'b000111, D8 = 6'b001000, D9 = 6'b001001;
    localparam logic [5:0] BLK = 6'b000000;

    // {c0..c4 (30), cap (3), value (17), tag (4), dig, zone, range}
    localparam int NVEC = 15;
    localparam logic [56:0] VEC [NVEC] = '{
        {D0, D1, D2, D3, D4, 3'd0, 17'd1234,  4'b0000, 3'b000},
        {D7, D9, D9, D9, D9, 3'd4, 17'd79999, 4'b0000, 3'b000},
        {D8, D0, D0, D0, D0, 3'd4, 17'd80000, 4'b0000, 3'b001},
        {D1, D0, D0, D0, D0, 3'd0, 17'd10000, 4'b0000, 3'b001},
        {D1, D0, D0, D0, D0, 3'd1, 17'd10000, 4'b0000, 3'b000},
        {D3, D9, D9, D9, D9, 3'd2, 17'd39999, 4'b0000, 3'b000},
        {D4, D0, D0, D0, D0, 3'd2, 17'd40000, 4'b0000, 3'b001},
        {D5, D9, D9, D9, D9, 3'd3, 17'd59999, 4'b0000, 3'b000},
        {D0, D0, 6'b100101, 6'b010001, D2, 3'd0, 17'd512, 4'b1001, 3'b000},
        {D0, D0, D0, D0, 6'b110011, 3'd0, 17'd3, 4'b0000, 3'b010},
        {D0, BLK, D1, D2, D3, 3'd0, 17'd123, 4'b0000, 3'b100},
        {D0, D0, D0, D0, 6'b001100, 3'd0, 17'd0, 4'b0000, 3'b100},
        {D1, D0, D0, D0, D0, 3'd7, 17'd10000, 4'b0000, 3'b001},
        {D9, D9, 6'b111001, 6'b101001, D9, 3'd4, 17'd99999, 4'b1110, 3'b001},
        {D0, 6'b010010, D0, D0, D0, 3'd0, 17'd2000, 4'b0000, 3'b010}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic put_char(input logic [5:0] c);
        @(negedge clk);
        char_vld = 1'b1;
        char_in  = c;
    endtask

    task automatic idle();
        @(negedge clk);
        char_vld = 1'b0;
        char_in  = '0;
    endtask

    task automatic send_addr(input logic [29:0] cs, input logic [2:0] sel);
        cap_sel = sel;
        for (int k = 0; k < 5; k++) put_char(cs[29 - 6*k -: 6]);
        idle();
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R1: watchdog expired, actual hung expected finish");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        check("R9 reset outputs", {done, addr_bin, index_tag, err_digit, err_zone, err_range}, 0);

        // Table walk: R1 R2 R3 R4 R5 R6
        for (int i = 0; i < NVEC; i++) begin
            logic [56:0] v;
            v = VEC[i];
            send_addr(v[56:27], v[26:24]);
            check("R1 done after fifth", 32'(done), 1);
            check("R1/R2/R3 addr value", 32'(addr_bin), 32'(v[23:7]));
            check("R5 index tag", 32'(index_tag), 32'(v[6:3]));
            check("R3/R4/R6 flags", {err_digit, err_zone, err_range}, 32'(v[2:0]));
            pulse_clr();
        end

        // R1 done lasts one cycle
        send_addr({D0, D0, D0, D0, D1}, 3'd0);
        check("R1 done high", 32'(done), 1);
        @(negedge clk);
        check("R1 done single cycle", 32'(done), 0);

        // R8 idle gaps between characters
        cap_sel = 3'd4;
        put_char(D4); idle(); idle();
        put_char(D2); idle();
        put_char(D7); put_char(D0); idle(); idle(); idle();
        put_char(D5); idle();
        check("R8 gaps keep partial", 32'(addr_bin), 42705);
        check("R8 gaps flags", {err_digit, err_zone, err_range}, 0);

        // R7 flags stay clear before the fifth character
        cap_sel = 3'd0;
        put_char(BLK); put_char(6'b110001); put_char(D0); put_char(D0); idle();
        check("R7 no flag before completion", {err_digit, err_zone}, 0);
        put_char(D0); idle();
        check("R7 flags at completion", {err_digit, err_zone}, 2'b11);

        // R7 sticky across a clean address
        send_addr({D0, D0, D0, D0, D1}, 3'd0);
        check("R7 sticky digit/zone", {err_digit, err_zone}, 2'b11);
        check("R7 clean value taken", 32'(addr_bin), 1);

        // R7 clear discards a partial address
        pulse_clr();
        check("R7 clear flags", {err_digit, err_zone, err_range}, 0);
        put_char(D9); put_char(D9); put_char(D9);
        @(negedge clk);
        char_vld = 1'b0;
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        send_addr({D0, D1, D2, D3, D4}, 3'd0);
        check("R7 partial discarded", 32'(addr_bin), 1234);
        check("R7 partial discarded flags", {err_digit, err_zone, err_range}, 0);

        // R9 reset clears sticky state
        send_addr({D9, D9, D9, D9, D9}, 3'd0);
        check("R6 range set", 32'(err_range), 1);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R9 reset clears", {addr_bin, index_tag, err_digit, err_zone, err_range}, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule